// File: doc/BRIEF.md
# Flash Region Lock and Security Controller

This block sits in front of a flash array and decides which commands may reach it. The array is divided into regions of consecutive pages, and each region carries one lock bit. Every page program or page erase is checked against the lock bit of the region it addresses. A command to a locked region never reaches the array: it completes at once with an abort flag, and a sticky interrupt is raised. Software-style commands set or clear single lock bits and set a security bit. No command can clear the security bit.

An external erase pin is synchronized and then timed with a slow tick. A high level that lasts past the qualification count clears every lock bit and starts a full array erase. The security bit is released only when that erase reports completion. While security is set, access requests from the debug port and from the parallel programming port are refused. On reset, the lock and security state load from a nonvolatile shadow input. Every change to that state is presented on a write-back port so it can be stored again.

Top module: `flk_guard`

## Requirements
- R1: Page address bits above the low PAGE_BITS bits select the region. A program (op 1) or page erase (op 2) to an unlocked region drives arrReq with arrOp 0 or 1 respectively and arrAddr equal to the command address. cmdDone pulses for one cycle, one cycle after arrDone is sampled.
- R2: A program or page erase to a region whose lock bit is set pulses cmdDone and cmdAbort together, one cycle after acceptance. It never raises arrReq, and it sets irq.
- R3: Set-lock (op 3) sets and clear-lock (op 4) clears the addressed region's bit. The change is visible on wbLocks one cycle after acceptance, together with a one-cycle wbValid pulse. A command that changes no bit gives no pulse.
- R4: irq stays set until irqClr is high at a clock edge. A new abort in the same cycle as irqClr leaves irq set.
- R5: statusLockErr shows whether the most recently completed command was aborted.
- R6: Set-security (op 5) sets statusSecure. No command clears it.
- R7: The erase pin qualifies only after it has been high through more than QUAL_TICKS slow ticks in a row. A shorter high level changes nothing.
- R8: On qualification, every lock bit clears. A full erase is then requested with arrOp 2 and arrAddr 0, and statusBusy stays high until it completes.
- R9: statusSecure falls only when arrDone completes a full erase.
- R10: While statusSecure is high, dbgGrant and ppGrant stay low. When it is low, they follow dbgReq and ppReq.
- R11: During reset, wbLocks loads nvLockInit and statusSecure loads nvSecInit. irq, cmdDone, arrReq and statusBusy are low.
- R12: Commands presented while statusBusy is high are ignored. An undefined op code (0, 6 or 7) completes with cmdDone and no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| slowTick | input | 1 | One-cycle enable from the slow timebase |
| erasePin | input | 1 | Asynchronous erase pin |
| cmdValid | input | 1 | Command present (sampled when not busy) |
| cmdOp | input | 3 | Command code |
| cmdAddr | input | log2(REGIONS)+PAGE_BITS | Page address |
| cmdDone | output | 1 | Command completed (one cycle) |
| cmdAbort | output | 1 | Completed command was refused by a lock |
| arrReq | output | 1 | Array operation requested |
| arrOp | output | 2 | 0 program, 1 page erase, 2 full erase |
| arrAddr | output | log2(REGIONS)+PAGE_BITS | Array page address |
| arrDone | input | 1 | Array operation finished |
| irq | output | 1 | Sticky lock-violation interrupt |
| irqClr | input | 1 | Write-one clear of irq |
| statusLockErr | output | 1 | Last command aborted |
| statusBusy | output | 1 | Operation in progress or pending |
| statusSecure | output | 1 | Security bit |
| nvLockInit | input | REGIONS | Lock bits loaded at reset |
| nvSecInit | input | 1 | Security bit loaded at reset |
| wbValid | output | 1 | Lock or security state just changed |
| wbLocks | output | REGIONS | Current lock bits |
| wbSec | output | 1 | Current security bit |
| dbgReq | input | 1 | Debug port access request |
| dbgGrant | output | 1 | Debug access allowed |
| ppReq | input | 1 | Parallel programming port request |
| ppGrant | output | 1 | Parallel programming access allowed |

## Verification
A corrupted lock bit shows up on wbLocks in the cycle after it changes. It also shows at the next command to that region, as an arrReq where an abort was due, or the other way round. A stuck control state shows as statusBusy held high and a missing cmdDone within a few cycles. A wrong security bit shows at once on dbgGrant and ppGrant. The erase-pin counter is visible only through its outcome, so its errors appear as an early or missing full-erase request a few ticks around the threshold.

// File: rtl/flk_pkg.sv
package flk_pkg;

  localparam logic [2:0] OP_PROG    = 3'd1;
  localparam logic [2:0] OP_ERASE   = 3'd2;
  localparam logic [2:0] OP_SETLOCK = 3'd3;
  localparam logic [2:0] OP_CLRLOCK = 3'd4;
  localparam logic [2:0] OP_SETSEC  = 3'd5;

  localparam logic [1:0] ARR_PROG  = 2'd0;
  localparam logic [1:0] ARR_PAGE  = 2'd1;
  localparam logic [1:0] ARR_FULL  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_ARRAY, ST_WIPE} flkState_e;

  // strobes from control to datapath, each valid for one cycle
  typedef struct packed {
    logic setLock;
    logic clrLock;
    logic setSec;
    logic clrSec;
    logic clrAll;
    logic raiseErr;
  } flkStrobe_t;

endpackage

// File: rtl/flk_pinqual.sv
module flk_pinqual #(
  parameter int QUAL_TICKS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowTick,
  input  logic pinAsync,
  output logic qualPulse
);
  localparam int CNT_W = $clog2(QUAL_TICKS + 2);

  logic syncA, syncB;
  logic [CNT_W-1:0] tickCnt;
  logic fired;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= pinAsync;
      syncB <= syncA;
    end
  end

  // count ticks while high; qualify on the tick that passes the limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt   <= '0;
      fired     <= 1'b0;
      qualPulse <= 1'b0;
    end else begin
      qualPulse <= 1'b0;
      if (!syncB) begin
        tickCnt <= '0;
        fired   <= 1'b0;
      end else if (slowTick && !fired) begin
        if (tickCnt == CNT_W'(QUAL_TICKS)) begin
          fired     <= 1'b1;
          qualPulse <= 1'b1;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flk_ctrl.sv
module flk_ctrl
  import flk_pkg::*;
#(
  parameter int REGIONS   = 8,
  parameter int PAGE_BITS = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [$clog2(REGIONS)+PAGE_BITS-1:0] cmdAddr,
  input  logic [REGIONS-1:0] lockVec,
  input  logic qualPulse,
  input  logic arrDone,
  output flkStrobe_t stb,
  output logic [$clog2(REGIONS)-1:0] regionIdx,
  output logic arrReq,
  output logic [1:0] arrOp,
  output logic [$clog2(REGIONS)+PAGE_BITS-1:0] arrAddr,
  output logic cmdDone,
  output logic cmdAbort,
  output logic lockErr,
  output logic busy
);
  localparam int REGION_BITS = $clog2(REGIONS);
  localparam int ADDR_W      = REGION_BITS + PAGE_BITS;

  flkState_e state;
  logic pending;
  logic [1:0] opQ;
  logic [ADDR_W-1:0] addrQ;

  logic accept, isArrayCmd, hitLocked;

  assign regionIdx  = cmdAddr[ADDR_W-1:PAGE_BITS];
  assign accept     = (state == ST_IDLE) && !pending && cmdValid;
  assign isArrayCmd = (cmdOp == OP_PROG) || (cmdOp == OP_ERASE);
  assign hitLocked  = lockVec[regionIdx];

  always_comb begin
    stb          = '0;
    stb.setLock  = accept && (cmdOp == OP_SETLOCK);
    stb.clrLock  = accept && (cmdOp == OP_CLRLOCK);
    stb.setSec   = accept && (cmdOp == OP_SETSEC);
    stb.raiseErr = accept && isArrayCmd && hitLocked;
    stb.clrAll   = qualPulse;
    stb.clrSec   = (state == ST_WIPE) && arrDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pending  <= 1'b0;
      opQ      <= ARR_PROG;
      addrQ    <= '0;
      cmdDone  <= 1'b0;
      cmdAbort <= 1'b0;
      lockErr  <= 1'b0;
    end else begin
      cmdDone  <= 1'b0;
      cmdAbort <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (pending) begin
            state   <= ST_WIPE;
            opQ     <= ARR_FULL;
            addrQ   <= '0;
            pending <= 1'b0;
          end else if (cmdValid) begin
            if (isArrayCmd && hitLocked) begin
              cmdDone  <= 1'b1;
              cmdAbort <= 1'b1;
              lockErr  <= 1'b1;
            end else if (isArrayCmd) begin
              state <= ST_ARRAY;
              opQ   <= (cmdOp == OP_PROG) ? ARR_PROG : ARR_PAGE;
              addrQ <= cmdAddr;
            end else begin
              cmdDone <= 1'b1;
              lockErr <= 1'b0;
            end
          end
        end
        ST_ARRAY: begin
          if (arrDone) begin
            state   <= ST_IDLE;
            cmdDone <= 1'b1;
            lockErr <= 1'b0;
          end
        end
        ST_WIPE: begin
          if (arrDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (qualPulse) pending <= 1'b1;
    end
  end

  assign arrReq  = (state == ST_ARRAY) || (state == ST_WIPE);
  assign arrOp   = opQ;
  assign arrAddr = addrQ;
  assign busy    = (state != ST_IDLE) || pending;
endmodule

// File: rtl/flk_data.sv
module flk_data
  import flk_pkg::*;
#(
  parameter int REGIONS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  flkStrobe_t stb,
  input  logic [$clog2(REGIONS)-1:0] regionIdx,
  input  logic [REGIONS-1:0] nvLockInit,
  input  logic nvSecInit,
  input  logic irqClr,
  input  logic dbgReq,
  input  logic ppReq,
  output logic [REGIONS-1:0] lockQ,
  output logic secQ,
  output logic irqQ,
  output logic wbValid,
  output logic dbgGrant,
  output logic ppGrant
);
  logic [REGIONS-1:0] lockNext;
  logic secNext;

  always_comb begin
    lockNext = lockQ;
    if (stb.clrAll)       lockNext = '0;
    else if (stb.setLock) lockNext[regionIdx] = 1'b1;
    else if (stb.clrLock) lockNext[regionIdx] = 1'b0;
  end

  always_comb begin
    secNext = secQ;
    if (stb.clrSec)      secNext = 1'b0;
    else if (stb.setSec) secNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ   <= nvLockInit;
      secQ    <= nvSecInit;
      irqQ    <= 1'b0;
      wbValid <= 1'b0;
    end else begin
      lockQ   <= lockNext;
      secQ    <= secNext;
      wbValid <= (lockNext != lockQ) || (secNext != secQ);
      if (stb.raiseErr)  irqQ <= 1'b1;
      else if (irqClr)   irqQ <= 1'b0;
    end
  end

  assign dbgGrant = dbgReq & ~secQ;
  assign ppGrant  = ppReq & ~secQ;
endmodule

// File: rtl/flk_guard.sv
module flk_guard
  import flk_pkg::*;
#(
  parameter int REGIONS    = 8,
  parameter int PAGE_BITS  = 2,
  parameter int QUAL_TICKS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowTick,
  input  logic erasePin,
  input  logic cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [$clog2(REGIONS)+PAGE_BITS-1:0] cmdAddr,
  output logic cmdDone,
  output logic cmdAbort,
  output logic arrReq,
  output logic [1:0] arrOp,
  output logic [$clog2(REGIONS)+PAGE_BITS-1:0] arrAddr,
  input  logic arrDone,
  output logic irq,
  input  logic irqClr,
  output logic statusLockErr,
  output logic statusBusy,
  output logic statusSecure,
  input  logic [REGIONS-1:0] nvLockInit,
  input  logic nvSecInit,
  output logic wbValid,
  output logic [REGIONS-1:0] wbLocks,
  output logic wbSec,
  input  logic dbgReq,
  output logic dbgGrant,
  input  logic ppReq,
  output logic ppGrant
);
  localparam int REGION_BITS = $clog2(REGIONS);

  flkStrobe_t stb;
  logic [REGION_BITS-1:0] regionIdx;
  logic [REGIONS-1:0] lockQ;
  logic secQ;
  logic qualPulse;

  flk_pinqual #(.QUAL_TICKS(QUAL_TICKS)) uQual (
    .clk(clk), .rstN(rstN), .slowTick(slowTick),
    .pinAsync(erasePin), .qualPulse(qualPulse)
  );

  flk_ctrl #(.REGIONS(REGIONS), .PAGE_BITS(PAGE_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .lockVec(lockQ), .qualPulse(qualPulse),
    .arrDone(arrDone), .stb(stb), .regionIdx(regionIdx),
    .arrReq(arrReq), .arrOp(arrOp), .arrAddr(arrAddr),
    .cmdDone(cmdDone), .cmdAbort(cmdAbort), .lockErr(statusLockErr),
    .busy(statusBusy)
  );

  flk_data #(.REGIONS(REGIONS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .regionIdx(regionIdx),
    .nvLockInit(nvLockInit), .nvSecInit(nvSecInit), .irqClr(irqClr),
    .dbgReq(dbgReq), .ppReq(ppReq), .lockQ(lockQ), .secQ(secQ),
    .irqQ(irq), .wbValid(wbValid), .dbgGrant(dbgGrant), .ppGrant(ppGrant)
  );

  assign wbLocks      = lockQ;
  assign wbSec        = secQ;
  assign statusSecure = secQ;
endmodule

// File: rtl/flk_guard_chk.sv
module flk_guard_chk #(
  parameter int REGIONS   = 8,
  parameter int PAGE_BITS = 2
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic [2:0] cmdOp,
  input logic [$clog2(REGIONS)+PAGE_BITS-1:0] cmdAddr,
  input logic cmdDone,
  input logic cmdAbort,
  input logic arrReq,
  input logic [1:0] arrOp,
  input logic arrDone,
  input logic irq,
  input logic irqClr,
  input logic statusBusy,
  input logic statusSecure,
  input logic wbValid,
  input logic [REGIONS-1:0] wbLocks,
  input logic dbgGrant,
  input logic ppGrant
);
  localparam int ADDR_W = $clog2(REGIONS) + PAGE_BITS;

  // R2: locked array command aborts without array access
  a_r2_locked_abort: assert property (@(posedge clk) disable iff (!rstN)
    (!statusBusy && cmdValid && (cmdOp == 3'd1 || cmdOp == 3'd2)
      && wbLocks[cmdAddr[ADDR_W-1:PAGE_BITS]])
    |=> (cmdDone && cmdAbort && !arrReq));

  // R4: irq held until cleared
  a_r4_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);

  // R3: lock bits change only with a write-back pulse
  a_r3_lock_change_flagged: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wbLocks) |-> wbValid);

  // R9: security falls only after a completed full erase
  a_r9_sec_clear_by_wipe: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusSecure) |-> $past(arrReq && arrDone && arrOp == 2'd2));

  // R6: security rises only from the set-security command
  a_r6_sec_set_by_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusSecure) |-> $past(cmdValid && cmdOp == 3'd5 && !statusBusy));

  // R10: no access grants while secure
  a_r10_gate: assert property (@(posedge clk) disable iff (!rstN)
    statusSecure |-> (!dbgGrant && !ppGrant));

  // R1: completion and array request never overlap
  a_r1_done_after_array: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> !arrReq);
endmodule

bind flk_guard flk_guard_chk #(.REGIONS(REGIONS), .PAGE_BITS(PAGE_BITS)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdAddr(cmdAddr), .cmdDone(cmdDone), .cmdAbort(cmdAbort),
  .arrReq(arrReq), .arrOp(arrOp), .arrDone(arrDone), .irq(irq),
  .irqClr(irqClr), .statusBusy(statusBusy), .statusSecure(statusSecure),
  .wbValid(wbValid), .wbLocks(wbLocks), .dbgGrant(dbgGrant),
  .ppGrant(ppGrant)
);

// File: tb/tb_flk_guard.sv
module tb_flk_guard;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b0;
  logic erasePin = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [4:0] cmdAddr = 5'd0;
  logic cmdDone, cmdAbort, arrReq;
  logic [1:0] arrOp;
  logic [4:0] arrAddr;
  logic arrDone = 1'b0;
  logic irq;
  logic irqClr = 1'b0;
  logic statusLockErr, statusBusy, statusSecure;
  logic [7:0] nvLockInit = 8'h04;
  logic nvSecInit = 1'b0;
  logic wbValid;
  logic [7:0] wbLocks;
  logic wbSec;
  logic dbgReq = 1'b1;
  logic dbgGrant;
  logic ppReq = 1'b1;
  logic ppGrant;

  int nChecks = 0;
  int nFails = 0;
  logic [1:0] tickCnt = 2'd0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickCnt  <= tickCnt + 2'd1;
    slowTick <= (tickCnt == 2'd3);
  end

  flk_guard dut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .erasePin(erasePin),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdDone(cmdDone), .cmdAbort(cmdAbort), .arrReq(arrReq),
    .arrOp(arrOp), .arrAddr(arrAddr), .arrDone(arrDone), .irq(irq),
    .irqClr(irqClr), .statusLockErr(statusLockErr),
    .statusBusy(statusBusy), .statusSecure(statusSecure),
    .nvLockInit(nvLockInit), .nvSecInit(nvSecInit), .wbValid(wbValid),
    .wbLocks(wbLocks), .wbSec(wbSec), .dbgReq(dbgReq),
    .dbgGrant(dbgGrant), .ppReq(ppReq), .ppGrant(ppGrant)
  );

  // {op, addr, expAbort, expLocks}; locks start at 8'h04
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {3'd1, 5'd5,  1'b0, 8'h04},
    {3'd1, 5'd9,  1'b1, 8'h04},
    {3'd2, 5'd11, 1'b1, 8'h04},
    {3'd3, 5'd4,  1'b0, 8'h06},
    {3'd2, 5'd7,  1'b1, 8'h06},
    {3'd4, 5'd10, 1'b0, 8'h02},
    {3'd1, 5'd8,  1'b0, 8'h02},
    {3'd3, 5'd31, 1'b0, 8'h82},
    {3'd1, 5'd31, 1'b1, 8'h82},
    {3'd2, 5'd0,  1'b0, 8'h82},
    {3'd7, 5'd12, 1'b0, 8'h82},
    {3'd3, 5'd5,  1'b0, 8'h82}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic runCmd(input logic [2:0] op, input logic [4:0] addr,
                        output logic sawArr, output logic [1:0] aOp,
                        output logic [4:0] aAddr, output logic aborted,
                        output logic wbSeen, output logic doneSeen);
    sawArr = 1'b0; aOp = 2'd0; aAddr = 5'd0; aborted = 1'b0;
    doneSeen = 1'b0;
    cmdOp = op; cmdAddr = addr; cmdValid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0;
    wbSeen = wbValid;
    for (int n = 0; n < 50; n++) begin
      if (cmdDone) begin
        aborted = cmdAbort; doneSeen = 1'b1;
        break;
      end
      if (arrReq) begin
        sawArr = 1'b1; aOp = arrOp; aAddr = arrAddr;
        arrDone = 1'b1;
        @(negedge clk);
        arrDone = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL R12 watchdog act=1 exp=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic sawArr, aborted, wbSeen, doneSeen, expIrq;
    logic [1:0] aOp;
    logic [4:0] aAddr;
    logic [7:0] prevLocks;

    doReset();
    // R11 reset state
    chk("R11 locks", wbLocks, 8'h04);
    chk("R11 sec", statusSecure, 1'b0);
    chk("R11 idle", {irq, cmdDone, arrReq, statusBusy}, 4'b0000);

    prevLocks = 8'h04;
    expIrq = 1'b0;
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [4:0] ad;
      logic eAb, isArr;
      logic [7:0] eL;
      {op, ad, eAb, eL} = VEC[i];
      isArr = (op == 3'd1 || op == 3'd2);
      runCmd(op, ad, sawArr, aOp, aAddr, aborted, wbSeen, doneSeen);
      chk("R2 done", doneSeen, 1'b1);
      chk("R2 abort", aborted, eAb);
      chk("R1 array access", sawArr, isArr && !eAb);
      if (isArr && !eAb) begin
        chk("R1 arrOp", aOp, op - 3'd1);
        chk("R1 arrAddr", aAddr, ad);
      end
      chk("R3 locks", wbLocks, eL);
      if (!isArr) chk("R3 wbValid", wbSeen, eL != prevLocks);
      chk("R5 lockErr", statusLockErr, eAb);
      expIrq = expIrq | eAb;
      chk("R2 irq", irq, expIrq);
      prevLocks = eL;
    end

    // R4 clear, then set wins over clear
    irqClr = 1'b1; @(negedge clk); irqClr = 1'b0;
    chk("R4 irq cleared", irq, 1'b0);
    cmdOp = 3'd1; cmdAddr = 5'd30; cmdValid = 1'b1; irqClr = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; irqClr = 1'b0;
    chk("R4 set wins", irq, 1'b1);
    @(negedge clk);
    irqClr = 1'b1; @(negedge clk); irqClr = 1'b0;

    // R12 command while busy ignored
    cmdOp = 3'd1; cmdAddr = 5'd0; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R12 busy", statusBusy, 1'b1);
    cmdOp = 3'd3; cmdAddr = 5'd1; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    arrDone = 1'b1; @(negedge clk); arrDone = 1'b0;
    chk("R1 done after arrDone", cmdDone, 1'b1);
    @(negedge clk);
    chk("R12 no extra done", cmdDone, 1'b0);
    chk("R12 locks unchanged", wbLocks, 8'h82);

    // R6 and R10 security set
    chk("R10 open grant", {dbgGrant, ppGrant}, 2'b11);
    runCmd(3'd5, 5'd0, sawArr, aOp, aAddr, aborted, wbSeen, doneSeen);
    chk("R6 secure set", statusSecure, 1'b1);
    chk("R6 wb pulse", {wbSeen, wbSec}, 2'b11);
    chk("R10 grants blocked", {dbgGrant, ppGrant}, 2'b00);
    runCmd(3'd4, 5'd31, sawArr, aOp, aAddr, aborted, wbSeen, doneSeen);
    chk("R6 not cleared by cmd", statusSecure, 1'b1);
    chk("R3 clear under secure", wbLocks, 8'h02);
    runCmd(3'd3, 5'd20, sawArr, aOp, aAddr, aborted, wbSeen, doneSeen);
    chk("R3 relock", wbLocks, 8'h22);

    // R7 short pulse ignored
    erasePin = 1'b1;
    repeat (40) @(negedge clk);
    erasePin = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 short pulse locks", wbLocks, 8'h22);
    chk("R7 short pulse no erase", {arrReq, statusBusy}, 2'b00);

    // R7/R8 long pulse qualifies
    erasePin = 1'b1;
    repeat (120) @(negedge clk);
    erasePin = 1'b0;
    chk("R8 locks cleared", wbLocks, 8'h00);
    chk("R8 full erase req", {arrReq, arrOp}, {1'b1, 2'd2});
    chk("R8 full erase addr", arrAddr, 5'd0);
    chk("R8 busy", statusBusy, 1'b1);
    chk("R9 secure held", statusSecure, 1'b1);
    repeat (5) @(negedge clk);
    chk("R9 secure before done", statusSecure, 1'b1);
    chk("R10 still blocked", {dbgGrant, ppGrant}, 2'b00);
    arrDone = 1'b1; @(negedge clk); arrDone = 1'b0;
    chk("R9 secure released", statusSecure, 1'b0);
    chk("R9 wb pulse", wbValid, 1'b1);
    chk("R10 grants back", {dbgGrant, ppGrant}, 2'b11);
    chk("R8 idle", {arrReq, statusBusy, cmdDone}, 3'b000);

    // R11 reset load with security
    nvLockInit = 8'h11; nvSecInit = 1'b1;
    doReset();
    chk("R11 locks reload", wbLocks, 8'h11);
    chk("R11 sec reload", statusSecure, 1'b1);
    chk("R11 irq", irq, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule